// File: doc/BRIEF.md
# Alternating-Compare PWM Timer Channel

This block is one 16-bit timer channel that builds a pulse-width waveform from two compare registers taken in turn. The counter starts from a programmable load value and advances on each cycle where a count tick arrives. When it reaches the value of the compare register that is currently active, three things happen together. The internal output level toggles, the other compare register becomes active, and (in length mode) the counter restarts from the load value.

One compare register times the low phase and the other times the high phase. Each compare register has a shadow preload register. A compare register takes its shadow value at the moment the opposite register matches, so new period and duty values take effect on a phase boundary and never cut a phase short.

Software programs the channel through a simple write port. The port reaches the compare, preload and load values, a control word, a flag-clear register and an interrupt-enable register. The waveform, the two sticky match flags and a combined interrupt line come out as ports.

Top module: `altcmp_pwm`

## Requirements
- R1: After reset, pwm_out, both match flags and irq are low.
- R2: Set up for up-counting in length mode, with load value 0, compare A = L-1 and compare B = H-1 and a tick on every cycle. After a control write, the internal level is low for L ticks, then high for H ticks, and this repeats. Each match toggles the level and makes the other compare register active.
- R3: With length mode off, a match does not reload the counter. The counter keeps stepping by one, wrapping modulo 2^16, and the level still toggles on every match.
- R4: Control bit 1 set selects down-counting. The counter decrements, and after a control write the first active compare is B rather than A.
- R5: Register map: address 0 is compare A, 1 is compare B, 2 is preload A, 3 is preload B, 4 is the load value, 5 is control, 6 is flag clear and 7 is interrupt enable. Compare A takes the value of preload A when compare B matches. Compare B takes the value of preload B when compare A matches. A direct write to a compare register takes effect on the next cycle.
- R6: The counter advances only on cycles where tick is high and the run bit (control bit 0) is set. In all other cycles the counter and the output level hold.
- R7: A control write with bit 5 set drives the internal level low on the next cycle. Bit 5 is not stored.
- R8: pwm_out equals the internal level XOR the polarity bit (control bit 4) when the output-enable bit (control bit 3) is set, and is 0 when output-enable is clear. Control bit 2 is length mode.
- R9: flags[0] is set by a match of compare A and flags[1] by a match of compare B. Both flags are sticky. Writing address 6 clears each flag whose data bit is 0. A match in the same cycle wins over the clear.
- R10: irq is the OR over both flags of the flag ANDed with its enable bit (address 7, bit 0 for flag A and bit 1 for flag B).
- R11: A control write reloads the counter from the load value. It selects compare A when bit 1 is 0 and compare B when bit 1 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| tick | input | 1 | Count enable for this cycle |
| pwm_out | output | 1 | Waveform output after enable and polarity |
| flags | output | 2 | Sticky match flags (bit 0 compare A, bit 1 compare B) |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is a preload write that lands while a phase is running. The new shadow value must be ignored by the current phase and applied only at the next match of the opposite register. A match that coincides with a flag-clear write or a control restart is similarly awkward. Directed sequences write the shadows a fixed number of cycles after a restart and then measure three consecutive phase lengths. A long random run then mixes gated ticks, shadow rewrites, flag clears and restarts, and compares every cycle against a bench model built from the requirements.

// File: rtl/altcmp_pkg.sv
package altcmp_pkg;

   typedef enum logic [2:0] {
      A_CMPA  = 3'd0,
      A_CMPB  = 3'd1,
      A_PREA  = 3'd2,
      A_PREB  = 3'd3,
      A_LOAD  = 3'd4,
      A_CTRL  = 3'd5,
      A_FLAG  = 3'd6,
      A_IEN   = 3'd7
   } reg_addr_e;

   // packed: last member is bit 0
   typedef struct packed {
      logic force_lo;
      logic pol;
      logic oen;
      logic len;
      logic down;
      logic run;
   } ctrl_t;

   localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/altcmp_slot.sv
module altcmp_slot #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_cmp,
   input  logic         wr_pre,
   input  logic [W-1:0] wr_data,
   input  logic         reload,
   output logic [W-1:0] cmp_o
);

   logic [W-1:0] cmp_q;
   logic [W-1:0] pre_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_q <= '0;
         pre_q <= '0;
      end else begin
         if (wr_pre) pre_q <= wr_data;
         if (wr_cmp)      cmp_q <= wr_data;
         else if (reload) cmp_q <= pre_q;
      end
   end

   assign cmp_o = cmp_q;

   // R5
   reload_takes_preload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reload && !wr_cmp) |=> (cmp_q == $past(pre_q)));

   // R5
   direct_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cmp |=> (cmp_q == $past(wr_data)));

endmodule

// File: rtl/altcmp_counter.sv
module altcmp_counter #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         restart,
   input  logic         restart_down,
   input  logic         run,
   input  logic         down,
   input  logic         len,
   input  logic         tick,
   input  logic [W-1:0] load_val,
   input  logic [W-1:0] cmp_a,
   input  logic [W-1:0] cmp_b,
   output logic         match_o,
   output logic         sel_b_o
);

   logic [W-1:0] cnt_q;
   logic         sel_q;
   logic         step;
   logic [W-1:0] active;
   logic [W-1:0] cnt_step;

   assign step     = run && tick;
   assign active   = sel_q ? cmp_b : cmp_a;
   assign match_o  = step && (cnt_q == active);
   assign cnt_step = down ? (cnt_q - 1'b1) : (cnt_q + 1'b1);
   assign sel_b_o  = sel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         sel_q <= 1'b0;
      end else if (restart) begin
         cnt_q <= load_val;
         sel_q <= restart_down;
      end else if (match_o) begin
         sel_q <= ~sel_q;
         cnt_q <= len ? load_val : cnt_step;
      end else if (step) begin
         cnt_q <= cnt_step;
      end
   end

   // R6
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!(run && tick) && !restart) |=> ($stable(cnt_q) && $stable(sel_q)));

   // R2
   alt_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (match_o && !restart) |=> (sel_q != $past(sel_q)));

   // R2
   len_reinit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (match_o && len && !restart) |=> (cnt_q == $past(load_val)));

   // R11
   restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> ((cnt_q == $past(load_val)) && (sel_q == $past(restart_down))));

endmodule

// File: rtl/altcmp_outflag.sv
module altcmp_outflag (
   input  logic clk,
   input  logic rst_n,
   input  logic force_lo,
   input  logic toggle,
   input  logic oen,
   input  logic pol,
   output logic pwm_o
);

   logic lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        lvl_q <= 1'b0;
      else if (force_lo) lvl_q <= 1'b0;
      else if (toggle)   lvl_q <= ~lvl_q;
   end

   assign pwm_o = oen & (lvl_q ^ pol);

   // R7
   force_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      force_lo |=> !lvl_q);

   // R2
   toggle_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (toggle && !force_lo) |=> (lvl_q != $past(lvl_q)));

endmodule

// File: rtl/altcmp_pwm.sv
module altcmp_pwm #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [2:0]       wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             tick,
   output logic             pwm_out,
   output logic [1:0]       flags,
   output logic             irq
);
   import altcmp_pkg::*;

   localparam int NSLOT = 2;

   if (CNT_W < CTRL_W || CNT_W > 32) begin : g_bad_width
      $error("altcmp_pwm: CNT_W must lie between control width and 32");
   end

   ctrl_t            ctrl_q;
   ctrl_t            ctrl_wd;
   logic [CNT_W-1:0] load_q;
   logic [1:0]       ien_q;
   logic [1:0]       flags_q;
   logic [1:0]       flags_nxt;
   logic             ctrl_wr;
   logic             flag_wr;
   logic             match;
   logic             sel_b;
   logic [CNT_W-1:0] cmp_v [NSLOT];

   assign ctrl_wr = wr_en && (wr_addr == A_CTRL);
   assign flag_wr = wr_en && (wr_addr == A_FLAG);
   assign ctrl_wd = ctrl_t'(wr_data[CTRL_W-1:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         load_q <= '0;
         ien_q  <= '0;
      end else if (wr_en) begin
         case (wr_addr)
            A_CTRL:  begin
               ctrl_q          <= ctrl_wd;
               ctrl_q.force_lo <= 1'b0;
            end
            A_LOAD:  load_q <= wr_data;
            A_IEN:   ien_q  <= wr_data[1:0];
            default: ;
         endcase
      end
   end

   for (genvar gi = 0; gi < NSLOT; gi++) begin : g_slot
      localparam logic OPP = (gi == 0);
      altcmp_slot #(.W(CNT_W)) u_slot (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_cmp  (wr_en && (wr_addr == 3'(gi))),
         .wr_pre  (wr_en && (wr_addr == 3'(gi + 2))),
         .wr_data (wr_data),
         .reload  (match && (sel_b == OPP)),
         .cmp_o   (cmp_v[gi])
      );
   end

   altcmp_counter #(.W(CNT_W)) u_cnt (
      .clk          (clk),
      .rst_n        (rst_n),
      .restart      (ctrl_wr),
      .restart_down (ctrl_wd.down),
      .run          (ctrl_q.run),
      .down         (ctrl_q.down),
      .len          (ctrl_q.len),
      .tick         (tick),
      .load_val     (load_q),
      .cmp_a        (cmp_v[0]),
      .cmp_b        (cmp_v[1]),
      .match_o      (match),
      .sel_b_o      (sel_b)
   );

   altcmp_outflag u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .force_lo (ctrl_wr && ctrl_wd.force_lo),
      .toggle   (match),
      .oen      (ctrl_q.oen),
      .pol      (ctrl_q.pol),
      .pwm_o    (pwm_out)
   );

   always_comb begin
      flags_nxt = flags_q;
      if (flag_wr) flags_nxt = flags_nxt & wr_data[1:0];
      if (match)   flags_nxt[sel_b] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q <= '0;
      else        flags_q <= flags_nxt;
   end

   assign flags = flags_q;
   assign irq   = |(flags_q & ien_q);

   // R9
   flag_a_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (match && !sel_b) |=> flags[0]);

   // R9
   flag_b_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (match && sel_b) |=> flags[1]);

   // R9
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[0] && !flag_wr) |=> flags[0]);

endmodule

// File: tb/altcmp_pwm_tb.sv
`timescale 1ns/1ps
module altcmp_pwm_tb;
   import altcmp_pkg::*;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_en = 1'b0;
   logic [2:0]   wr_addr = '0;
   logic [W-1:0] wr_data = '0;
   logic         tick = 1'b0;
   wire          pwm_out;
   wire  [1:0]   flags;
   wire          irq;

   int    n_chk = 0;
   int    n_bad = 0;
   string tag = "R1";
   bit    chk_on = 1'b0;
   bit    done = 1'b0;

   altcmp_pwm #(.CNT_W(W)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .tick(tick), .pwm_out(pwm_out), .flags(flags), .irq(irq)
   );

   always #2.5 clk = ~clk;

   // reference model built from the requirements
   logic [W-1:0] m_cnt, m_load;
   logic [W-1:0] m_cmp [2];
   logic [W-1:0] m_pre [2];
   logic         m_sel, m_lvl;
   logic [5:0]   m_ctrl;
   logic [1:0]   m_flags, m_ien;

   always @(posedge clk) begin : mdl
      logic st, mt;
      logic [W-1:0] act, nx;
      if (!rst_n) begin
         m_cnt = '0; m_load = '0; m_sel = 0; m_lvl = 0; m_ctrl = '0;
         m_flags = '0; m_ien = '0;
         for (int k = 0; k < 2; k++) begin m_cmp[k] = '0; m_pre[k] = '0; end
      end else begin
         st  = m_ctrl[0] && tick;
         act = m_sel ? m_cmp[1] : m_cmp[0];
         mt  = st && (m_cnt == act);
         nx  = m_ctrl[1] ? m_cnt - 1'b1 : m_cnt + 1'b1;
         for (int k = 0; k < 2; k++) begin
            if (wr_en && wr_addr == 3'(k)) m_cmp[k] = wr_data;
            else if (mt && (m_sel == (k == 0))) m_cmp[k] = m_pre[k];
         end
         if (wr_en && wr_addr == 3'd5 && wr_data[5]) m_lvl = 1'b0;
         else if (mt) m_lvl = ~m_lvl;
         if (wr_en && wr_addr == 3'd6) m_flags = m_flags & wr_data[1:0];
         if (mt) m_flags[m_sel] = 1'b1;
         if (wr_en && wr_addr == 3'd5) begin
            m_cnt = m_load; m_sel = wr_data[1];
         end else if (mt) begin
            m_sel = ~m_sel; m_cnt = m_ctrl[2] ? m_load : nx;
         end else if (st) m_cnt = nx;
         if (wr_en && wr_addr == 3'd2) m_pre[0] = wr_data;
         if (wr_en && wr_addr == 3'd3) m_pre[1] = wr_data;
         if (wr_en && wr_addr == 3'd4) m_load = wr_data;
         if (wr_en && wr_addr == 3'd7) m_ien = wr_data[1:0];
         if (wr_en && wr_addr == 3'd5) m_ctrl = {1'b0, wr_data[4:0]};
      end
   end

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (chk_on) begin
         chk(tag,  "pwm",   32'(pwm_out), 32'(m_ctrl[3] & (m_lvl ^ m_ctrl[4])));
         chk("R9", "flags", 32'(flags),   32'(m_flags));
         chk("R10","irq",   32'(irq),     32'(|(m_flags & m_ien)));
      end
   end

   task automatic wreg(input logic [2:0] a, input logic [W-1:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic run_len(input logic lvl, output int n);
      n = 0;
      while (pwm_out == lvl && n < 200) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic cfg(input int ca, input int cb, input int ld, input logic [5:0] c);
      wreg(A_PREA, W'(ca)); wreg(A_PREB, W'(cb));
      wreg(A_CMPA, W'(ca)); wreg(A_CMPB, W'(cb));
      wreg(A_LOAD, W'(ld));
      wreg(A_CTRL, W'(c));
   endtask

   initial begin
      int a, b, c;
      logic dn;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1", "pwm", 32'(pwm_out), 0);
      chk("R1", "flags", 32'(flags), 0);
      chk("R1", "irq", 32'(irq), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk_on = 1'b1;
      tick = 1'b1;

      // R2 basic alternating phases: low 5, high 3
      tag = "R2";
      cfg(4, 2, 0, 6'h2D);
      run_len(1'b0, a); run_len(1'b1, b); run_len(1'b0, c);
      chk("R2", "low phase", 32'(a), 5);
      chk("R2", "high phase", 32'(b), 3);
      chk("R2", "second low phase", 32'(c), 5);

      // R7 force low during high phase, R11 restart
      tag = "R7";
      while (pwm_out == 1'b0) @(negedge clk);
      wreg(A_CTRL, 16'h2D);
      chk("R7", "forced low", 32'(pwm_out), 0);
      tag = "R11";
      run_len(1'b0, a);
      chk("R11", "low after restart", 32'(a), 5);

      // R6 gated ticks
      tag = "R6";
      wreg(A_CTRL, 16'h2D);
      @(negedge clk); @(negedge clk);
      tick = 1'b0;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         chk("R6", "held low", 32'(pwm_out), 0);
      end
      tick = 1'b1;
      run_len(1'b0, a);
      chk("R6", "remaining low", 32'(a), 3);

      // R5 preload applied at opposite match
      tag = "R5";
      wreg(A_CTRL, 16'h2D);
      wreg(A_PREA, 16'd1);
      wreg(A_PREB, 16'd6);
      run_len(1'b0, a); run_len(1'b1, b); run_len(1'b0, c);
      chk("R5", "low unchanged", 32'(a), 3);
      chk("R5", "high from preload B", 32'(b), 7);
      chk("R5", "low from preload A", 32'(c), 2);

      // R3 no reload in non-length mode
      tag = "R3";
      cfg(3, 10, 0, 6'h29);
      run_len(1'b0, a); run_len(1'b1, b);
      chk("R3", "low phase", 32'(a), 4);
      chk("R3", "high phase", 32'(b), 7);

      // R4 down counting, compare B first
      tag = "R4";
      cfg(15, 17, 20, 6'h2F);
      run_len(1'b0, a); run_len(1'b1, b);
      chk("R4", "first phase", 32'(a), 4);
      chk("R4", "second phase", 32'(b), 6);

      // R8 polarity and output enable
      tag = "R8";
      wreg(A_CTRL, 16'h3D);
      chk("R8", "inverted level", 32'(pwm_out), 1);
      wreg(A_CTRL, 16'h25);
      for (int i = 0; i < 30; i++) begin
         chk("R8", "disabled output", 32'(pwm_out), 0);
         @(negedge clk);
      end

      // R9 / R10 flag clear and interrupt enables
      tag = "R9";
      wreg(A_CTRL, 16'h0C);
      chk("R9", "both flags", 32'(flags), 3);
      wreg(A_FLAG, 16'h1);
      chk("R9", "flag B cleared", 32'(flags), 1);
      wreg(A_IEN, 16'h2);
      chk("R10", "masked irq", 32'(irq), 0);
      wreg(A_IEN, 16'h1);
      chk("R10", "enabled irq", 32'(irq), 1);

      // random mix against the model
      tag = "R2";
      dn = 1'b0;
      cfg(5, 7, 0, 6'h2D);
      for (int i = 0; i < 4000; i++) begin
         int r;
         logic [W-1:0] rv;
         tick = ($urandom % 4) != 0;
         r = $urandom % 24;
         rv = dn ? W'(10 + $urandom % 30) : W'($urandom % 21);
         case (r)
            0: wreg(A_PREA, rv);
            1: wreg(A_PREB, rv);
            2: wreg(A_FLAG, W'($urandom % 4));
            3: wreg(A_IEN, W'($urandom % 4));
            4: begin
               if ($urandom % 8 == 0) begin
                  dn = $urandom % 2;
                  wreg(A_LOAD, dn ? 16'd40 : 16'd0);
                  wreg(A_CTRL, W'({1'($urandom % 2), 1'($urandom % 2), 4'b1101} | {5'b0, dn, 1'b0}));
               end else @(negedge clk);
            end
            default: @(negedge clk);
         endcase
      end

      chk_on = 1'b0;
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL R6 watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

endmodule